// File: doc/BRIEF.md
# Threshold Monitor Interrupt Controller

This block watches a set of sampled monitor readings from an optical module: a signed temperature, a supply voltage, and for each of four lanes the transmit bias current, transmit power and receive power. Every reading is compared against four programmable limits whenever a sample strobe arrives. Each limit crossing, and each rising edge of a discrete status event, sets a sticky flag. Every flag that is not masked pulls a single active-low interrupt line low.

A host reaches the block through a plain register port with one-cycle read latency. Through it the host programs limits and masks. It finds the cause of an interrupt by reading flag registers. These are split per parameter and per lane, and inside each register by alarm or warning level and by direction. A read of a flag register returns its latched bits and clears them, which releases the line once nothing unmasked remains.

Top module: `thr_irq_ctrl`

## Requirements
- R1: After reset every flag reads 0 and `irq_n` is 1. All masks are 0. A temperature high limit reads 0x7FFF and a temperature low limit reads 0x8000. Every other high limit reads 0xFFFF and every other low limit reads 0x0000.
- R2: On a cycle with `smp_valid` high, a high limit is crossed when the value is strictly greater than the limit, and a low limit is crossed when the value is strictly less than the limit. Values presented while `smp_valid` is low set no flag.
- R3: Temperature values and temperature limits compare as signed two's complement. All other channels compare as unsigned.
- R4: Channels are numbered 0 temperature, 1 supply, 2..5 bias of lanes 0..3, 6..9 transmit power of lanes 0..3, and 10..13 receive power of lanes 0..3. The flag register of channel c sits at address 0x40+c. In it, bit0 is high alarm, bit1 low alarm, bit2 high warning and bit3 low warning.
- R5: A flag is set only on a sample where its violation starts. A violation that persists across samples does not set the flag again after a clear. It sets it again only after the value has returned inside the limit and then crossed it again.
- R6: A read presents data on `reg_rdata` after the next rising edge. Reading a flag register (channel or event) returns the latched bits and clears them. Reading a limit or a mask register clears nothing.
- R7: When a flag is newly set in the same cycle as a clearing read of its register, the read returns the old contents and the new flag stays latched.
- R8: A rising edge on `ev_ready`, `ev_txflt[l]` or `ev_los[l]` sets bit0, bit 1+l or bit 5+l of the event flag register at 0x50. A level held high does not set the bit again.
- R9: `irq_n` is 0 exactly while at least one flag is set whose mask bit is 0.
- R10: The mask of channel c is at 0x60+c, with bits 3:0 matching the flag bits. The event mask is at 0x70, with bits 8:0 matching the event bits. A masked flag still latches and reads back but does not drive `irq_n`.
- R11: The limit k of channel c is read and written at address 4c+k, with k=0 high alarm, 1 low alarm, 2 high warning and 3 low warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe: compare all readings this cycle |
| temp_val | input | 16 | Temperature reading, signed |
| vcc_val | input | 16 | Supply voltage reading |
| bias_val | input | 64 | Bias readings, lane l at bits 16l+15:16l |
| txp_val | input | 64 | Transmit power readings, packed per lane |
| rxp_val | input | 64 | Receive power readings, packed per lane |
| ev_ready | input | 1 | Data-ready status event |
| ev_txflt | input | 4 | Per-lane transmit fault events |
| ev_los | input | 4 | Per-lane loss-of-signal events |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid after the edge that takes the read |
| irq_n | output | 1 | Aggregated active-low interrupt |

## Verification
Assertions check several rules on every cycle. A flag only appears after a sample strobe. A clearing read without a sample leaves the channel empty. A limit write lands in the next cycle. The interrupt is never low without a latched flag, and it is high in the first cycle after reset. The bench scenarios are needed for the rest. They show the exact strict and signed comparison at each limit boundary and the edge-only re-arming across repeated samples. They also cover the ordering when a set and a clearing read collide, the bit positions in each register, and the masking effect on the line.

// File: rtl/tmic_pkg.sv
package tmic_pkg;

    localparam int VAL_W      = 16;
    localparam int ADDR_W     = 8;
    localparam int LIM_PER_CH = 4;

    typedef logic [VAL_W-1:0]  val_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // limit slot order inside a channel; even slots are high-side checks
    typedef enum logic [1:0] {
        LIM_HI_ALM = 2'd0,
        LIM_LO_ALM = 2'd1,
        LIM_HI_WRN = 2'd2,
        LIM_LO_WRN = 2'd3
    } lim_kind_e;

    // packed so that hi_alm lands on bit0
    typedef struct packed {
        logic lo_wrn;
        logic hi_wrn;
        logic lo_alm;
        logic hi_alm;
    } flag4_t;

    localparam addr_t FLG_BASE = 8'h40;
    localparam addr_t EVT_FLG  = 8'h50;
    localparam addr_t MSK_BASE = 8'h60;
    localparam addr_t EVT_MSK  = 8'h70;

    function automatic logic high_side(int k);
        return (k % 2) == 0;
    endfunction

    function automatic logic crosses(val_t v, val_t lim, logic sgn, logic hi);
        logic gt, lt;
        if (sgn) begin
            gt = $signed(v) > $signed(lim);
            lt = $signed(v) < $signed(lim);
        end else begin
            gt = v > lim;
            lt = v < lim;
        end
        return hi ? gt : lt;
    endfunction

    function automatic val_t default_limit(logic sgn, logic hi);
        val_t r;
        if (hi) r = sgn ? {1'b0, {(VAL_W-1){1'b1}}} : {VAL_W{1'b1}};
        else    r = sgn ? {1'b1, {(VAL_W-1){1'b0}}} : {VAL_W{1'b0}};
        return r;
    endfunction

endpackage

// File: rtl/tmic_chan_mon.sv
module tmic_chan_mon
    import tmic_pkg::*;
#(
    parameter bit SIGNED_VAL = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        smp_valid,
    input  val_t                        value,
    input  logic [LIM_PER_CH-1:0]       lim_we,
    input  val_t                        wdata,
    input  logic                        clr,
    output flag4_t                      flags,
    output val_t [LIM_PER_CH-1:0]       lims
);

    val_t [LIM_PER_CH-1:0] lim_q;
    logic [LIM_PER_CH-1:0] hit;
    logic [LIM_PER_CH-1:0] prev_hit;
    logic [LIM_PER_CH-1:0] rise;
    logic [LIM_PER_CH-1:0] flag_q;

    for (genvar k = 0; k < LIM_PER_CH; k++) begin : g_lim
        always_ff @(posedge clk) begin
            if (rst)
                lim_q[k] <= default_limit(SIGNED_VAL, high_side(k));
            else if (lim_we[k])
                lim_q[k] <= wdata;
        end
        assign hit[k] = crosses(value, lim_q[k], SIGNED_VAL, high_side(k));

        a_r11_lim_write: assert property (@(posedge clk) disable iff (rst)
            lim_we[k] |=> lim_q[k] == $past(wdata));
    end

    // violation history only advances on samples, so re-arming needs an in-range sample
    always_ff @(posedge clk) begin
        if (rst)            prev_hit <= '0;
        else if (smp_valid) prev_hit <= hit;
    end

    assign rise = smp_valid ? (hit & ~prev_hit) : '0;

    // a newly rising flag survives a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (clr ? '0 : flag_q) | rise;
    end

    assign flags = flag4_t'(flag_q);
    assign lims  = lim_q;

    a_r2_set_needs_sample: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & ~$past(flag_q)) != '0) |-> $past(smp_valid));

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr && !smp_valid) |=> flag_q == '0);

endmodule

// File: rtl/tmic_evt_mon.sv
module tmic_evt_mon #(
    parameter int NEV = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] ev_in,
    input  logic           clr,
    output logic [NEV-1:0] flags
);

    logic [NEV-1:0] prev_ev;
    logic [NEV-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ev <= '0;
            flag_q  <= '0;
        end else begin
            prev_ev <= ev_in;
            flag_q  <= (clr ? '0 : flag_q) | (ev_in & ~prev_ev);
        end
    end

    assign flags = flag_q;

    a_r8_evt_needs_edge: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & ~$past(flag_q)) != '0) |-> ($past(ev_in) & ~$past(prev_ev)) != '0);

    a_r6_evt_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && (ev_in & ~prev_ev) == '0) |=> flag_q == '0);

endmodule

// File: rtl/tmic_irq_agg.sv
module tmic_irq_agg #(
    parameter int W = 65
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    output logic         irq_n
);

    assign irq_n = ~(|(flags & ~mask));

endmodule

// File: rtl/thr_irq_ctrl.sv
module thr_irq_ctrl
    import tmic_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic [VAL_W-1:0]           temp_val,
    input  logic [VAL_W-1:0]           vcc_val,
    input  logic [NUM_LANES*VAL_W-1:0] bias_val,
    input  logic [NUM_LANES*VAL_W-1:0] txp_val,
    input  logic [NUM_LANES*VAL_W-1:0] rxp_val,
    input  logic                       ev_ready,
    input  logic [NUM_LANES-1:0]       ev_txflt,
    input  logic [NUM_LANES-1:0]       ev_los,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [VAL_W-1:0]           reg_wdata,
    output logic [VAL_W-1:0]           reg_rdata,
    output logic                       irq_n
);

    localparam int NCH    = 2 + 3 * NUM_LANES;
    localparam int NEV    = 1 + 2 * NUM_LANES;
    localparam int CH_FW  = NCH * LIM_PER_CH;
    localparam int ALL_FW = CH_FW + NEV;

    val_t   ch_val  [NCH];
    flag4_t ch_flg  [NCH];
    val_t [LIM_PER_CH-1:0] ch_lim [NCH];
    logic [LIM_PER_CH-1:0] ch_msk [NCH];
    logic [NCH-1:0]        ch_clr;
    logic [NEV-1:0]        ev_vec;
    logic [NEV-1:0]        ev_flg;
    logic [NEV-1:0]        ev_msk;
    logic                  ev_clr;
    logic [ALL_FW-1:0]     all_flags;
    logic [ALL_FW-1:0]     all_mask;
    val_t                  rd_mux;
    val_t                  rdata_q;

    // channel value routing
    assign ch_val[0] = temp_val;
    assign ch_val[1] = vcc_val;
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_route
        assign ch_val[2 + l]               = bias_val[l*VAL_W +: VAL_W];
        assign ch_val[2 + NUM_LANES + l]   = txp_val [l*VAL_W +: VAL_W];
        assign ch_val[2 + 2*NUM_LANES + l] = rxp_val [l*VAL_W +: VAL_W];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [LIM_PER_CH-1:0] we;
        for (genvar k = 0; k < LIM_PER_CH; k++) begin : g_we
            assign we[k] = reg_wr && (reg_addr == addr_t'(c*LIM_PER_CH + k));
        end
        assign ch_clr[c] = reg_rd && (reg_addr == FLG_BASE + addr_t'(c));

        tmic_chan_mon #(.SIGNED_VAL(c == 0)) u_mon (
            .clk      (clk),
            .rst      (rst),
            .smp_valid(smp_valid),
            .value    (ch_val[c]),
            .lim_we   (we),
            .wdata    (reg_wdata),
            .clr      (ch_clr[c]),
            .flags    (ch_flg[c]),
            .lims     (ch_lim[c])
        );

        always_ff @(posedge clk) begin
            if (rst)
                ch_msk[c] <= '0;
            else if (reg_wr && reg_addr == MSK_BASE + addr_t'(c))
                ch_msk[c] <= reg_wdata[LIM_PER_CH-1:0];
        end

        assign all_flags[c*LIM_PER_CH +: LIM_PER_CH] = ch_flg[c];
        assign all_mask [c*LIM_PER_CH +: LIM_PER_CH] = ch_msk[c];
    end

    // discrete events: ready, then per-lane tx fault, then per-lane loss of signal
    assign ev_vec = {ev_los, ev_txflt, ev_ready};
    assign ev_clr = reg_rd && (reg_addr == EVT_FLG);

    tmic_evt_mon #(.NEV(NEV)) u_evt (
        .clk  (clk),
        .rst  (rst),
        .ev_in(ev_vec),
        .clr  (ev_clr),
        .flags(ev_flg)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ev_msk <= '0;
        else if (reg_wr && reg_addr == EVT_MSK)
            ev_msk <= reg_wdata[NEV-1:0];
    end

    assign all_flags[CH_FW +: NEV] = ev_flg;
    assign all_mask [CH_FW +: NEV] = ev_msk;

    tmic_irq_agg #(.W(ALL_FW)) u_agg (
        .flags(all_flags),
        .mask (all_mask),
        .irq_n(irq_n)
    );

    // read decode
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < LIM_PER_CH; k++) begin
                if (reg_addr == addr_t'(c*LIM_PER_CH + k))
                    rd_mux = ch_lim[c][k];
            end
            if (reg_addr == FLG_BASE + addr_t'(c))
                rd_mux = val_t'(ch_flg[c]);
            if (reg_addr == MSK_BASE + addr_t'(c))
                rd_mux = val_t'(ch_msk[c]);
        end
        if (reg_addr == EVT_FLG) rd_mux = val_t'(ev_flg);
        if (reg_addr == EVT_MSK) rd_mux = val_t'(ev_msk);
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    a_r1_line_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_n);

    a_r9_line_has_source: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (|all_flags));

    a_r10_mask_blocks_line: assert property (@(posedge clk) disable iff (rst)
        ((all_flags & ~all_mask) == '0) |-> irq_n);

endmodule

// File: tb/thr_irq_ctrl_tb.sv
module thr_irq_ctrl_tb;

    localparam int NL  = 4;
    localparam int NCH = 2 + 3 * NL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic ev_ready = 1'b0;
    logic [NL-1:0] ev_txflt = '0;
    logic [NL-1:0] ev_los = '0;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq_n;
    logic [15:0] cval [NCH];
    logic [NL*16-1:0] bias_v, txp_v, rxp_v;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    int lim [NCH][4];
    bit prevv [NCH][4];
    int mflag [NCH];

    always #10 clk = ~clk;

    always_comb begin
        for (int l = 0; l < NL; l++) begin
            bias_v[l*16 +: 16] = cval[2 + l];
            txp_v [l*16 +: 16] = cval[2 + NL + l];
            rxp_v [l*16 +: 16] = cval[2 + 2*NL + l];
        end
    end

    thr_irq_ctrl #(.NUM_LANES(NL)) u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .temp_val(cval[0]), .vcc_val(cval[1]),
        .bias_val(bias_v), .txp_val(txp_v), .rxp_val(rxp_v),
        .ev_ready(ev_ready), .ev_txflt(ev_txflt), .ev_los(ev_los),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic int as_int(int c, logic [15:0] v);
        return (c == 0) ? int'($signed(v)) : int'(v);
    endfunction

    // reference model of one sample, from R2/R3/R5
    task automatic samp();
        @(negedge clk);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 4; k++) begin
                int v;
                bit viol;
                v = as_int(c, cval[c]);
                viol = (k % 2 == 0) ? (v > lim[c][k]) : (v < lim[c][k]);
                if (viol && !prevv[c][k]) mflag[c] |= (1 << k);
                prevv[c][k] = viol;
            end
        end
    endtask

    function automatic int sweep_val(int c, int s);
        int mid;
        mid = (lim[c][3] + lim[c][2]) / 2;
        case (s)
            0: return mid;
            1: return lim[c][0] + 1;
            2: return lim[c][0] + 1;
            3: return mid;
            4: return lim[c][0];
            5: return lim[c][0] + 1;
            6: return lim[c][1] - 1;
            7: return lim[c][3];
            8: return lim[c][3] - 1;
            9: return lim[c][2] + 1;
            10: return lim[c][1];
            default: return mid;
        endcase
    endfunction

    initial begin
        logic [15:0] d;
        for (int c = 0; c < NCH; c++) cval[c] = 16'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_n", int'(irq_n), 1);
        rd(8'h00, d); chk("R1 temp high default", int'(d), 16'h7FFF);
        rd(8'h01, d); chk("R1 temp low default", int'(d), 16'h8000);
        rd(8'h06, d); chk("R1 supply high warn default", int'(d), 16'hFFFF);
        rd(8'h07, d); chk("R1 supply low warn default", int'(d), 16'h0000);
        rd(8'h60, d); chk("R1 mask default", int'(d), 0);
        rd(8'h50, d); chk("R1 event flags", int'(d), 0);
        for (int c = 0; c < NCH; c++) begin
            rd(8'h40 + 8'(c), d); chk("R1 channel flags", int'(d), 0);
        end

        // R11: program and read back every limit
        for (int c = 0; c < NCH; c++) begin
            if (c == 0) begin
                lim[c][0] = 50; lim[c][1] = -10; lim[c][2] = 40; lim[c][3] = -5;
            end else begin
                lim[c][0] = 1000 + 10*c; lim[c][1] = 100 + c;
                lim[c][2] = 800 + 10*c;  lim[c][3] = 200 + c;
            end
            for (int k = 0; k < 4; k++) begin
                prevv[c][k] = 1'b0;
                wr(8'(4*c + k), 16'(lim[c][k]));
            end
            mflag[c] = 0;
        end
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 4; k++) begin
                rd(8'(4*c + k), d); chk("R11 limit readback", int'(d), lim[c][k] & 16'hFFFF);
            end

        // R2 R3 R4 R5 R6 R9: boundary sweep on all channels at once
        for (int s = 0; s < 12; s++) begin
            for (int c = 0; c < NCH; c++) cval[c] = 16'(sweep_val(c, s));
            samp();
            begin
                bit any;
                any = 1'b0;
                for (int c = 0; c < NCH; c++) if (mflag[c] != 0) any = 1'b1;
                chk("R9 irq_n after sample", int'(irq_n), any ? 0 : 1);
            end
            for (int c = 0; c < NCH; c++) begin
                rd(8'h40 + 8'(c), d);
                chk("R2/R3/R4/R5 flag register", int'(d), mflag[c]);
                mflag[c] = 0;
            end
            chk("R6 irq_n released after reads", int'(irq_n), 1);
        end

        // R2: values without the strobe are ignored
        for (int c = 0; c < NCH; c++) cval[c] = 16'(lim[c][0] + 5);
        repeat (3) @(negedge clk);
        chk("R2 no strobe irq_n", int'(irq_n), 1);
        rd(8'h41, d); chk("R2 no strobe flags", int'(d), 0);
        for (int c = 0; c < NCH; c++) cval[c] = 16'(sweep_val(c, 0));
        samp();

        // R6: reading a limit clears nothing
        cval[1] = 16'(lim[1][0] + 1);
        samp();
        rd(8'h04, d); chk("R6 limit read", int'(d), lim[1][0]);
        rd(8'h41, d); chk("R6 flags survive limit read", int'(d), 5);

        // R7: set collides with clearing read
        cval[1] = 16'd50;
        samp();
        cval[1] = 16'd500;
        samp();
        @(negedge clk);
        cval[1] = 16'(lim[1][0] + 1);
        smp_valid = 1'b1; reg_rd = 1'b1; reg_addr = 8'h41;
        @(negedge clk);
        smp_valid = 1'b0; reg_rd = 1'b0;
        chk("R7 read returns old flags", int'(reg_rdata), 16'hA);
        chk("R7 line held", int'(irq_n), 0);
        rd(8'h41, d); chk("R7 new flag kept", int'(d), 16'h5);
        cval[1] = 16'(sweep_val(1, 0));
        samp();

        // R8: discrete events, edge only
        @(negedge clk);
        ev_ready = 1'b1; ev_txflt[2] = 1'b1; ev_los[3] = 1'b1;
        @(negedge clk);
        chk("R8 irq on event", int'(irq_n), 0);
        rd(8'h50, d); chk("R8 event bits", int'(d), 16'h109);
        rd(8'h50, d); chk("R8 held level no reset", int'(d), 0);
        chk("R8 irq released", int'(irq_n), 1);
        ev_ready = 1'b0; ev_txflt = '0; ev_los = '0;
        @(negedge clk);
        ev_los[0] = 1'b1;
        @(negedge clk);
        rd(8'h50, d); chk("R8 los lane0 bit", int'(d), 16'h020);
        ev_los = '0;

        // R10: masks
        wr(8'h60, 16'hF);
        rd(8'h60, d); chk("R10 mask readback", int'(d), 16'hF);
        cval[0] = 16'(lim[0][0] + 1);
        samp();
        chk("R10 masked temp no irq", int'(irq_n), 1);
        rd(8'h40, d); chk("R10 masked flag latched", int'(d), 16'h5);
        wr(8'h70, 16'h001);
        @(negedge clk);
        ev_ready = 1'b1;
        @(negedge clk);
        chk("R10 masked event no irq", int'(irq_n), 1);
        ev_txflt[1] = 1'b1;
        @(negedge clk);
        chk("R10 unmasked event irq", int'(irq_n), 0);
        rd(8'h50, d); chk("R10 event flags", int'(d), 16'h005);
        chk("R9 irq released", int'(irq_n), 1);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule